// File: doc/BRIEF.md
# Two-Entry Token Handoff FIFO

This block is a small register FIFO placed between two dataflow compute stages. A producer offers a token made of a data word, a one-bit end-of-vector marker and a one-bit exception flag. It pulses a write strobe when it offers a token, and it watches a full flag. The consumer sees the oldest token on its output. A flag tells the consumer that a token is waiting. After the consumer has taken the token, it pulses a read strobe to drop it.

The block holds two token registers. Because of this, the first write raises the data-waiting flag, and full rises only on a later cycle. The two flags never change on the same clock edge. The three fields of a token are stored together and come out together, unchanged. The exception flag reports an upstream error, such as a divide by zero. The end-of-vector marker is set on the last element of each vector. Tokens leave in the order they arrived. A synchronous active-high reset empties the block.

Top module: `tok_pipe2`

## Requirements
- R1: While reset is high, and in the first cycle after it goes low, `full` and `avail` are both 0.
- R2: `avail` is 1 when at least one token is stored. `full` is 1 only when both entries are in use, and `full` implies `avail`.
- R3: One accepted write into an empty block raises `avail` on the next cycle and leaves `full` at 0. A second write with no read raises `full`. `full` and `avail` never both change on the same edge.
- R4: Tokens are presented on `rd_*` in the order in which they were accepted.
- R5: The `wr_last` and `wr_exc` bits of a token appear on `rd_last` and `rd_exc` together with that token's data, unchanged.
- R6: While `avail` is 1 and `rd_en` is 0, `rd_data`, `rd_last` and `rd_exc` hold their values on the next cycle.
- R7: A write while `full` is 1 and no read is present is ignored. `full` stays 1, and the stored tokens come out later unchanged.
- R8: A read while `avail` is 0 is ignored. If no write is present, `avail` stays 0, and a later write is the first token read out.
- R9: A read and a write in the same cycle, with exactly one token stored, keep `avail`=1 and `full`=0. The written token becomes the head on the next cycle.
- R10: A read and a write in the same cycle while full are handled as follows. The read drops the head. The write is ignored because the block was full at that edge. On the next cycle `full` is 0 and the former second token is the head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe: the input token is valid |
| wr_data | input | DATA_W | Data word of the input token |
| wr_last | input | 1 | End-of-vector marker of the input token |
| wr_exc | input | 1 | Exception flag of the input token |
| full | output | 1 | Both entries hold tokens |
| rd_en | input | 1 | Read strobe: drop the head token |
| rd_data | output | DATA_W | Data word of the head token |
| rd_last | output | 1 | End-of-vector marker of the head token |
| rd_exc | output | 1 | Exception flag of the head token |
| avail | output | 1 | At least one token is stored |

## Verification
The bench first pushes a single token and then two back-to-back tokens. This shows whether `avail` and `full` rise on separate edges or together. Streams with a different marker and exception pattern on each token show whether the fields stay with their own data and whether the order is kept. The strobes are then driven in the corners: writes against a full block, reads from an empty block, and read plus write together at occupancy one and at occupancy two. These patterns separate "dropped" from "accepted" and show which side wins when both act at once. Idle gaps with a token waiting show whether the head holds steady.

// File: rtl/tok_pipe_pkg.sv
package tok_pipe_pkg;

    localparam int unsigned DEF_DATA_W = 32;
    localparam int unsigned DEF_DEPTH  = 2;

    // Per-cycle storage action, decoded from the accepted strobes.
    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_PUSH = 2'b01,
        OP_POP  = 2'b10,
        OP_SWAP = 2'b11
    } op_e;

    function automatic op_e op_of(input logic push, input logic pop);
        return op_e'({pop, push});
    endfunction

endpackage

// File: rtl/tok_pipe_ctrl.sv
module tok_pipe_ctrl
    import tok_pipe_pkg::*;
#(
    parameter int unsigned DEPTH = DEF_DEPTH,
    localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_req,
    input  logic          rd_req,
    output logic          wr_fire,
    output logic [PW-1:0] wr_ptr,
    output logic [PW-1:0] rd_ptr,
    output logic          full,
    output logic          avail
);

    logic [CW-1:0] count;
    logic          rd_fire;
    op_e           op;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count == CW'(DEPTH));
    assign avail   = (count != '0);
    assign wr_fire = wr_req && !full;
    assign rd_fire = rd_req && avail;
    assign op      = op_of(wr_fire, rd_fire);

    always_ff @(posedge clk) begin
        if (rst) begin
            count  <= '0;
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            case (op)
                OP_PUSH: begin
                    count  <= count + 1'b1;
                    wr_ptr <= bump(wr_ptr);
                end
                OP_POP: begin
                    count  <= count - 1'b1;
                    rd_ptr <= bump(rd_ptr);
                end
                OP_SWAP: begin
                    wr_ptr <= bump(wr_ptr);
                    rd_ptr <= bump(rd_ptr);
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/tok_pipe_store.sv
module tok_pipe_store #(
    parameter int unsigned DEPTH = 2,
    parameter int unsigned TOK_W = 34,
    localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [PW-1:0]    wptr,
    input  logic [TOK_W-1:0] wtok,
    input  logic [PW-1:0]    rptr,
    output logic [TOK_W-1:0] rtok
);

    logic [TOK_W-1:0] slots [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                slots[g] <= '0;
            else if (we && wptr == PW'(g))
                slots[g] <= wtok;
        end
    end

    assign rtok = slots[rptr];

endmodule

// File: rtl/tok_pipe2.sv
module tok_pipe2
    import tok_pipe_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W,
    parameter int unsigned DEPTH  = DEF_DEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_last,
    input  logic              wr_exc,
    output logic              full,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_last,
    output logic              rd_exc,
    output logic              avail
);

    localparam int unsigned PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned TOK_W = DATA_W + 2;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              last;
        logic              exc;
    } tok_t;

    tok_t          in_tok, out_tok;
    logic          wr_fire;
    logic [PW-1:0] wr_ptr, rd_ptr;

    assign in_tok = '{data: wr_data, last: wr_last, exc: wr_exc};

    tok_pipe_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .wr_req (wr_en),
        .rd_req (rd_en),
        .wr_fire(wr_fire),
        .wr_ptr (wr_ptr),
        .rd_ptr (rd_ptr),
        .full   (full),
        .avail  (avail)
    );

    tok_pipe_store #(.DEPTH(DEPTH), .TOK_W(TOK_W)) u_store (
        .clk (clk),
        .rst (rst),
        .we  (wr_fire),
        .wptr(wr_ptr),
        .wtok(in_tok),
        .rptr(rd_ptr),
        .rtok(out_tok)
    );

    assign rd_data = out_tok.data;
    assign rd_last = out_tok.last;
    assign rd_exc  = out_tok.exc;

endmodule

// File: rtl/tok_pipe2_chk.sv
module tok_pipe2_chk #(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic              full,
    input logic              avail,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_last,
    input logic              rd_exc
);

    a_r1_reset_empty: assert property (@(posedge clk)
        rst |=> (!full && !avail));

    a_r2_full_has_data: assert property (@(posedge clk) disable iff (rst)
        full |-> avail);

    a_r3_flags_apart: assert property (@(posedge clk) disable iff (rst)
        !(!$stable(full) && !$stable(avail)));

    a_r6_head_hold: assert property (@(posedge clk) disable iff (rst)
        (avail && !rd_en) |=> (avail && $stable(rd_data) && $stable(rd_last) && $stable(rd_exc)));

    a_r7_full_write_dropped: assert property (@(posedge clk) disable iff (rst)
        (full && wr_en && !rd_en) |=> full);

    a_r8_empty_read_dropped: assert property (@(posedge clk) disable iff (rst)
        (!avail && rd_en && !wr_en) |=> !avail);

    a_r9_swap_keeps_level: assert property (@(posedge clk) disable iff (rst)
        (avail && !full && wr_en && rd_en) |=> (avail && !full));

    a_r10_full_swap_drains: assert property (@(posedge clk) disable iff (rst)
        (full && wr_en && rd_en) |=> (avail && !full));

endmodule

bind tok_pipe2 tok_pipe2_chk #(.DATA_W(DATA_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .full   (full),
    .avail  (avail),
    .rd_data(rd_data),
    .rd_last(rd_last),
    .rd_exc (rd_exc)
);

// File: tb/sim_tok_pipe2.sv
module sim_tok_pipe2;

    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          wr_en, wr_last, wr_exc, rd_en;
    logic [DW-1:0] wr_data;
    logic          full, avail, rd_last, rd_exc;
    logic [DW-1:0] rd_data;

    int nvec = 0;
    int nbad = 0;
    bit done = 1'b0;

    // bench-side model: q[0] is the head
    logic [DW+1:0] q [2];
    int qn = 0;

    always #5 clk = ~clk;

    tok_pipe2 #(.DATA_W(DW), .DEPTH(2)) u0 (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_data(wr_data), .wr_last(wr_last), .wr_exc(wr_exc),
        .full(full),
        .rd_en(rd_en), .rd_data(rd_data), .rd_last(rd_last), .rd_exc(rd_exc),
        .avail(avail)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk({tag, " full"}, 64'(full), 64'(qn == 2));
        chk({tag, " avail"}, 64'(avail), 64'(qn != 0));
        if (qn != 0)
            chk({tag, " head"}, 64'({rd_data, rd_last, rd_exc}), 64'(q[0]));
    endtask

    // drive one cycle after a negedge, update the model at the edge,
    // check half a period later
    task automatic cyc(input string tag, input logic w, input logic [DW-1:0] d,
                       input logic l, input logic e, input logic r);
        logic rok, wok;
        wr_en = w; wr_data = d; wr_last = l; wr_exc = e; rd_en = r;
        rok = r && qn > 0;
        wok = w && qn < 2;
        @(posedge clk);
        if (rok) begin q[0] = q[1]; qn--; end
        if (wok) begin q[qn] = {d, l, e}; qn++; end
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check_all(tag);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        wr_en = 0; rd_en = 0; wr_data = '0; wr_last = 0; wr_exc = 0;
        repeat (2) @(negedge clk);
        chk("R1 flags in reset", 64'({full, avail}), 64'(0));
        rst = 1'b0;
        qn = 0;
        @(negedge clk);
        chk("R1 flags after reset", 64'({full, avail}), 64'(0));
    endtask

    task automatic t_single();
        cyc("R3 one write", 1, 32'hA5A5_0001, 0, 1, 0);
        chk("R3 one write not full", 64'(full), 64'(0));
        chk("R2 avail after write", 64'(avail), 64'(1));
        cyc("R3 second write", 1, 32'hA5A5_0002, 1, 0, 0);
        chk("R3 full after two", 64'(full), 64'(1));
        cyc("R4 drain 1", 0, '0, 0, 0, 1);
        cyc("R4 drain 2", 0, '0, 0, 0, 1);
        chk("R2 empty after drain", 64'(avail), 64'(0));
    endtask

    task automatic t_order();
        for (int i = 0; i < 8; i++) begin
            cyc("R5 fields in", 1, 32'h1000 + 32'(i), i[0], i[1], 0);
            cyc("R4 order out", 0, '0, 0, 0, 1);
        end
        cyc("R5 pair a", 1, 32'hBEEF, 1, 1, 0);
        cyc("R5 pair b", 1, 32'hCAFE, 0, 0, 0);
        cyc("R4 pop a", 0, '0, 0, 0, 1);
        chk("R5 head data b", 64'(rd_data), 64'(32'hCAFE));
        cyc("R4 pop b", 0, '0, 0, 0, 1);
    endtask

    task automatic t_hold();
        cyc("R6 load", 1, 32'h7777, 1, 0, 0);
        for (int i = 0; i < 3; i++)
            cyc("R6 idle hold", 0, 32'hFFFF_FFFF, 0, 1, 0);
        chk("R6 held data", 64'(rd_data), 64'(32'h7777));
        cyc("R6 release", 0, '0, 0, 0, 1);
    endtask

    task automatic t_full_write();
        cyc("R7 fill 1", 1, 32'h11, 0, 0, 0);
        cyc("R7 fill 2", 1, 32'h22, 1, 1, 0);
        cyc("R7 write on full", 1, 32'h33, 0, 1, 0);
        chk("R7 still full", 64'(full), 64'(1));
        cyc("R7 out 1", 0, '0, 0, 0, 1);
        chk("R7 second kept", 64'(rd_data), 64'(32'h22));
        cyc("R7 out 2", 0, '0, 0, 0, 1);
        chk("R7 dropped token absent", 64'(avail), 64'(0));
    endtask

    task automatic t_empty_read();
        cyc("R8 read on empty", 0, '0, 0, 0, 1);
        cyc("R8 read on empty again", 0, '0, 0, 0, 1);
        chk("R8 still empty", 64'(avail), 64'(0));
        cyc("R8 later write", 1, 32'h4242, 0, 1, 0);
        chk("R8 first token", 64'({rd_data, rd_exc}), 64'({32'h4242, 1'b1}));
        cyc("R8 clear", 0, '0, 0, 0, 1);
    endtask

    task automatic t_swap_one();
        cyc("R9 seed", 1, 32'h500, 0, 0, 0);
        cyc("R9 swap", 1, 32'h501, 1, 0, 1);
        chk("R9 level", 64'({full, avail}), 64'(2'b01));
        chk("R9 new head", 64'(rd_data), 64'(32'h501));
        cyc("R9 swap again", 1, 32'h502, 0, 1, 1);
        cyc("R9 clear", 0, '0, 0, 0, 1);
    endtask

    task automatic t_swap_full();
        cyc("R10 fill 1", 1, 32'h600, 0, 0, 0);
        cyc("R10 fill 2", 1, 32'h601, 1, 1, 0);
        cyc("R10 swap on full", 1, 32'h602, 0, 0, 1);
        chk("R10 level", 64'({full, avail}), 64'(2'b01));
        chk("R10 head", 64'({rd_data, rd_last, rd_exc}), 64'({32'h601, 2'b11}));
        cyc("R10 clear", 0, '0, 0, 0, 1);
        chk("R10 empty", 64'(avail), 64'(0));
    endtask

    initial begin
        do_reset();
        t_single();
        t_order();
        t_hold();
        t_full_write();
        t_empty_read();
        t_swap_one();
        t_swap_full();
        do_reset();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            nvec++;
            nbad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

endmodule